// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers level-sensitive interrupt requests into two CPU interrupt lines. Two first-level groups of eight sources each have a status byte and a mask byte. A bit counts toward its group's CPU line only when both its status bit and its mask bit are 1. A third, second-level group of eight sources has one shared status byte and two independent mask bytes. Each mask gives its own masked view of that status. When any bit survives the first view, bit 7 of group 0's status is set. When any bit survives the second view, bit 3 of group 1's status is set. A second-level request therefore reaches the CPU only when it passes both its second-level mask and the first-level mask bit of the cascade position.

Software reaches the registers through a byte-wide port with one address bus, a write strobe and a read strobe. Read data is registered and appears one cycle after the strobe. Source levels pass through a two-stage synchronizer before they reach the status bytes. Each CPU line is registered once.

Software numbers the sources as follows: group 0 bits are sources 0 to 7 and group 1 bits are 8 to 15. Second-level bits seen through mask 0 are 16 to 23, and the same bits seen through mask 1 are 24 to 31.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four mask bytes read 0 and both `cpu_irq` outputs are 0.
- R2: Mask bytes are read/write. Group 0 mask is at address 0x1 and group 1 mask is at 0x3. A read returns exactly the last written value on `rd_data`, one cycle after the cycle in which `rd_en` is sampled.
- R3: Group 0 status reads at 0x0 and group 1 status reads at 0x2. Each reflects its source levels two clock edges after they change, with bit i equal to source bit i, and the cascade bit ORed in.
- R4: `cpu_irq[0]` is the registered OR over bits of (group 0 status AND group 0 mask). It rises one edge after a mask write enables a pending bit. It falls three edges after the source level drops (two synchronizer edges plus the output register).
- R5: `cpu_irq[1]` is the registered OR over bits of (group 1 status AND group 1 mask), with the same timing as R4.
- R6: The second-level status reads at 0x4. Second-level mask 0 is at 0x5 and mask 1 is at 0x9, which is mask 0's address plus 4. Both masks are read/write.
- R7: If (second-level status AND mask 0) is non-zero, group 0 status bit 7 reads 1; otherwise it follows source bit 7.
- R8: If (second-level status AND mask 1) is non-zero, group 1 status bit 3 reads 1. Mask 1 acts independently of mask 0 and does not affect group 0.
- R9: With every mask byte at 0, both `cpu_irq` outputs stay 0 whatever the source levels.
- R10: Writes to the three status addresses and to unmapped addresses change no register. Reads of unmapped addresses return 0.
- R11: A second-level request raises `cpu_irq[0]` only when group 0 mask bit 7 is also 1 (double masking).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc0_src | input | 8 | Group 0 source levels, active high |
| loc1_src | input | 8 | Group 1 source levels, active high |
| map_src | input | 8 | Second-level source levels, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cpu_irq | output | 2 | Per-group CPU interrupt request |

## Verification
A corrupted mask byte shows up on the next read of its address, one cycle after the strobe. It also shows up on `cpu_irq` one edge after a source it should pass or block is pending. A wrong cascade fold appears as a wrong bit 7 or bit 3 in a first-level status read, and as an interrupt line that fires or stays quiet against the second-level mask. The bench also probes the exact edge counts from mask write and from source change to `cpu_irq`. A delay stage added or dropped is therefore seen within three cycles.

// File: rtl/irq_cascade_pkg.sv
// Package: shared widths, the register address map and group constants
// for the cascaded interrupt controller.
package irq_cascade_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int NUM_LOCAL = 2;
    localparam int NUM_MAP_MASKS = 2;
    localparam int MAP_MASK_STRIDE = 4;

    typedef logic [ADDR_W-1:0] reg_addr_t;
    typedef logic [BYTE_W-1:0] reg_byte_t;

    localparam reg_addr_t ADR_L0_STAT   = 4'h0;
    localparam reg_addr_t ADR_L0_MASK   = 4'h1;
    localparam reg_addr_t ADR_L1_STAT   = 4'h2;
    localparam reg_addr_t ADR_L1_MASK   = 4'h3;
    localparam reg_addr_t ADR_MAP_STAT  = 4'h4;
    localparam reg_addr_t ADR_MAP_MASK0 = 4'h5;
    localparam reg_addr_t ADR_MAP_MASK1 = ADR_MAP_MASK0 + reg_addr_t'(MAP_MASK_STRIDE);

    // Bit of each first-level group that carries the folded second-level view.
    localparam int CASCADE_BIT_L0 = 7;
    localparam int CASCADE_BIT_L1 = 3;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Two-stage synchronizer for a vector of level-sensitive sources.
// Assumes: sources are levels held for several cycles; bits are independent.
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two flops in series; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// One byte-wide writable mask register decoded at a fixed address.
// Assumes: a write strobe and address valid in the same cycle.
module irq_mask_reg
    import irq_cascade_pkg::*;
#(
    parameter int        W    = BYTE_W,
    parameter reg_addr_t ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_addr_t     addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  mask_o
);
    logic hit;
    assign hit = wr_en && (addr == ADDR);

    // Load on an address match; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask_o <= '0;
        else if (hit) mask_o <= wr_data;
    end

    assert_mask_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR) |=> (mask_o == $past(wr_data)))
        else $error("mask register did not take written value");

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR) |=> $stable(mask_o))
        else $error("mask register changed without a matching write");
endmodule

// File: rtl/irq_map_group.sv
// Module: irq_map_group
// Second-level group: one shared status vector seen through NUM_MAP_MASKS
// independent mask registers, each giving a one-bit "any pending" summary.
// Assumes: src_sync_i is already synchronized.
module irq_map_group
    import irq_cascade_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int N = NUM_MAP_MASKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src_sync_i,
    input  logic          wr_en,
    input  reg_addr_t     addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  status_o,
    output logic [W-1:0]  mask_o [N],
    output logic [N-1:0]  any_o
);
    assign status_o = src_sync_i;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_view
            localparam reg_addr_t VIEW_ADDR =
                ADR_MAP_MASK0 + reg_addr_t'(g * MAP_MASK_STRIDE);

            irq_mask_reg #(.W(W), .ADDR(VIEW_ADDR)) i_mask (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .addr    (addr),
                .wr_data (wr_data),
                .mask_o  (mask_o[g])
            );

            // Fold this masked view into a single request bit.
            always_comb any_o[g] = |(status_o & mask_o[g]);
        end
    endgenerate

    assert_view_independent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_MAP_MASK0) |=> $stable(mask_o[N-1]))
        else $error("writing mask 0 disturbed mask 1");
endmodule

// File: rtl/irq_local_group.sv
// Module: irq_local_group
// First-level group: synchronized sources plus one cascade input folded
// into CASCADE_BIT, a mask register, and a registered CPU request.
// Assumes: src_sync_i synchronized; cascade_i comes from the same clock.
module irq_local_group
    import irq_cascade_pkg::*;
#(
    parameter int        W           = BYTE_W,
    parameter int        CASCADE_BIT = 7,
    parameter reg_addr_t MASK_ADDR   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src_sync_i,
    input  logic          cascade_i,
    input  logic          wr_en,
    input  reg_addr_t     addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  status_o,
    output logic [W-1:0]  mask_o,
    output logic          irq_o
);
    logic [W-1:0] fold_vec;
    logic         pend_any;

    // Place the cascade request on its fixed bit position.
    always_comb begin
        fold_vec = '0;
        fold_vec[CASCADE_BIT] = cascade_i;
    end

    assign status_o = src_sync_i | fold_vec;

    irq_mask_reg #(.W(W), .ADDR(MASK_ADDR)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .mask_o  (mask_o)
    );

    assign pend_any = |(status_o & mask_o);

    // Register the group's CPU request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pend_any;
    end

    // Holds for both groups: group 0 is R4, group 1 is R5.
    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_o & mask_o)) |=> irq_o)
        else $error("pending masked bit did not raise irq");

    assert_zero_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |=> !irq_o)
        else $error("irq raised with an all-zero mask");

    assert_cascade_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_i |-> status_o[CASCADE_BIT])
        else $error("cascade request missing from status");
endmodule

// File: rtl/irq_regport.sv
// Module: irq_regport
// Registered byte read multiplexer over all status and mask registers.
// Assumes: one read strobe per cycle; data holds until the next strobe.
module irq_regport
    import irq_cascade_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  reg_addr_t     addr,
    input  logic [W-1:0]  l0_status,
    input  logic [W-1:0]  l0_mask,
    input  logic [W-1:0]  l1_status,
    input  logic [W-1:0]  l1_mask,
    input  logic [W-1:0]  map_status,
    input  logic [W-1:0]  map_mask0,
    input  logic [W-1:0]  map_mask1,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] sel_data;

    // Decode the address to a register byte; unmapped reads return 0.
    always_comb begin
        unique case (addr)
            ADR_L0_STAT:   sel_data = l0_status;
            ADR_L0_MASK:   sel_data = l0_mask;
            ADR_L1_STAT:   sel_data = l1_status;
            ADR_L1_MASK:   sel_data = l1_mask;
            ADR_MAP_STAT:  sel_data = map_status;
            ADR_MAP_MASK0: sel_data = map_mask0;
            ADR_MAP_MASK1: sel_data = map_mask1;
            default:       sel_data = '0;
        endcase
    end

    // Capture the selected byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_data;
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > ADR_MAP_MASK1) |=> (rd_data == '0))
        else $error("unmapped read returned non-zero");

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data))
        else $error("read data changed without a strobe");
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module: cascade_irq_ctrl (top)
// Two first-level interrupt groups and one doubly masked second-level
// group whose masked views fold into fixed first-level bits.
// Assumes: level sources; single clock; byte register port.
module cascade_irq_ctrl
    import irq_cascade_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTE_W-1:0]    loc0_src,
    input  logic [BYTE_W-1:0]    loc1_src,
    input  logic [BYTE_W-1:0]    map_src,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NUM_LOCAL-1:0] cpu_irq
);
    localparam int SRC_W = BYTE_W * (NUM_LOCAL + 1);

    logic [SRC_W-1:0]         src_sync;
    logic [BYTE_W-1:0]        map_status;
    logic [BYTE_W-1:0]        map_mask [NUM_MAP_MASKS];
    logic [NUM_MAP_MASKS-1:0] map_any;
    logic [BYTE_W-1:0]        loc_status [NUM_LOCAL];
    logic [BYTE_W-1:0]        loc_mask   [NUM_LOCAL];
    logic [BYTE_W-1:0]        loc_src    [NUM_LOCAL];

    assign loc_src[0] = src_sync[0 +: BYTE_W];
    assign loc_src[1] = src_sync[BYTE_W +: BYTE_W];

    irq_sync #(.W(SRC_W)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({map_src, loc1_src, loc0_src}),
        .sync_o  (src_sync)
    );

    irq_map_group #(.W(BYTE_W), .N(NUM_MAP_MASKS)) i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sync_i (src_sync[2*BYTE_W +: BYTE_W]),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .status_o   (map_status),
        .mask_o     (map_mask),
        .any_o      (map_any)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LOCAL; g++) begin : g_local
            localparam int        CBIT  = (g == 0) ? CASCADE_BIT_L0 : CASCADE_BIT_L1;
            localparam reg_addr_t MADDR = (g == 0) ? ADR_L0_MASK : ADR_L1_MASK;

            irq_local_group #(.W(BYTE_W), .CASCADE_BIT(CBIT), .MASK_ADDR(MADDR)) i_grp (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_sync_i (loc_src[g]),
                .cascade_i  (map_any[g]),
                .wr_en      (wr_en),
                .addr       (addr),
                .wr_data    (wr_data),
                .status_o   (loc_status[g]),
                .mask_o     (loc_mask[g]),
                .irq_o      (cpu_irq[g])
            );
        end
    endgenerate

    irq_regport #(.W(BYTE_W)) i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr       (addr),
        .l0_status  (loc_status[0]),
        .l0_mask    (loc_mask[0]),
        .l1_status  (loc_status[1]),
        .l1_mask    (loc_mask[1]),
        .map_status (map_status),
        .map_mask0  (map_mask[0]),
        .map_mask1  (map_mask[1]),
        .rd_data    (rd_data)
    );

    assert_cascade_l1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(map_status & map_mask[1])) |-> loc_status[1][CASCADE_BIT_L1])
        else $error("mask 1 view not folded into group 1");

    assert_double_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_mask[0] == 8'h80 && loc_src[0] == '0 && !(|(map_status & map_mask[0])))
        |=> !cpu_irq[0])
        else $error("irq 0 raised with only the cascade bit enabled and no view hit");

    assert_stat_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADR_L0_STAT || addr == ADR_L1_STAT || addr == ADR_MAP_STAT))
        |=> ($stable(loc_mask[0]) && $stable(loc_mask[1])
             && $stable(map_mask[0]) && $stable(map_mask[1])))
        else $error("write to a status address changed a mask");
endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] loc0_src = '0;
    logic [7:0] loc1_src = '0;
    logic [7:0] map_src = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] cpu_irq;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;
    bit summary_printed = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    cascade_irq_ctrl i_cascade_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .loc0_src(loc0_src), .loc1_src(loc1_src),
        .map_src(map_src), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    // Monitor: note reads sampled at each edge, compare at the next falling edge.
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rd_data !== e) begin
                n_fails++;
                $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue a read and push the expected byte to the scoreboard.
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic [1:0] e, input string t);
        n_checks++;
        if (cpu_irq !== e) begin
            n_fails++;
            $display("FAIL %s: cpu_irq actual %b expected %b", t, cpu_irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!summary_printed) begin
            summary_printed = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        end
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk_irq(2'b00, "R1");
        rd(4'h1, 8'h00, "R1");
        rd(4'h3, 8'h00, "R1");
        rd(4'h5, 8'h00, "R1");
        rd(4'h9, 8'h00, "R1");

        // R2 and R6: mask write and readback
        wr(4'h1, 8'h5A); rd(4'h1, 8'h5A, "R2");
        wr(4'h3, 8'hC3); rd(4'h3, 8'hC3, "R2");
        wr(4'h5, 8'h81); rd(4'h5, 8'h81, "R6");
        wr(4'h9, 8'h7E); rd(4'h9, 8'h7E, "R6");
        rd(4'h5, 8'h81, "R6");
        wr(4'h1, 8'h00); wr(4'h3, 8'h00); wr(4'h5, 8'h00); wr(4'h9, 8'h00);

        // R9: sources active, masks zero
        loc0_src = 8'h3C; loc1_src = 8'h81; map_src = 8'hF0;
        idle(4);
        chk_irq(2'b00, "R9");
        // R3: status reflects sources; R6: second-level status
        rd(4'h0, 8'h3C, "R3");
        rd(4'h2, 8'h81, "R3");
        rd(4'h4, 8'hF0, "R6");

        // R4: mask write enables a pending bit, irq one edge later
        wr(4'h1, 8'h04);
        chk_irq(2'b00, "R4");
        idle(1);
        chk_irq(2'b01, "R4");
        // R4: source drop reaches irq after three edges
        @(negedge clk); loc0_src = 8'h00;
        idle(2);
        chk_irq(2'b01, "R4");
        idle(1);
        chk_irq(2'b00, "R4");

        // R5: group 1
        wr(4'h3, 8'h01);
        idle(2);
        chk_irq(2'b10, "R5");
        loc1_src = 8'h00;
        idle(4);
        chk_irq(2'b00, "R5");

        // R7 and R11: view 0 hit, but first-level bit 7 still masked
        wr(4'h5, 8'h10);
        idle(2);
        rd(4'h0, 8'h80, "R7");
        chk_irq(2'b00, "R11");
        wr(4'h1, 8'h80);
        idle(2);
        chk_irq(2'b01, "R11");
        wr(4'h5, 8'h0F);
        idle(2);
        chk_irq(2'b00, "R7");
        rd(4'h0, 8'h00, "R7");

        // R8: view 1 folds into group 1 bit 3 only
        wr(4'h3, 8'h08);
        idle(2);
        chk_irq(2'b00, "R8");
        wr(4'h9, 8'h20);
        idle(2);
        chk_irq(2'b10, "R8");
        rd(4'h2, 8'h08, "R8");
        rd(4'h0, 8'h00, "R8");
        rd(4'h5, 8'h0F, "R8");

        // R10: writes to status and unmapped addresses ignored
        wr(4'h0, 8'hFF); wr(4'h2, 8'hFF); wr(4'h4, 8'hFF); wr(4'hF, 8'hFF);
        rd(4'h1, 8'h80, "R10");
        rd(4'h3, 8'h08, "R10");
        rd(4'h5, 8'h0F, "R10");
        rd(4'h9, 8'h20, "R10");
        rd(4'hF, 8'h00, "R10");
        chk_irq(2'b10, "R10");

        // R9: all masks cleared with every source high
        loc0_src = 8'hFF; loc1_src = 8'hFF; map_src = 8'hFF;
        wr(4'h1, 8'h00); wr(4'h3, 8'h00); wr(4'h5, 8'h00); wr(4'h9, 8'h00);
        idle(4);
        chk_irq(2'b00, "R9");
        rd(4'h0, 8'hFF, "R3");

        idle(2);
        done = 1'b1;
        finish_run();
    end
endmodule